// File: doc/BRIEF.md
# Row-Hit-First Bank Request Scheduler

This block sits in front of a DRAM command engine and holds the memory requests that are waiting for service. Requests arrive on an enqueue port with a bank, a row, a direction and a tag. Reads and writes are kept in two independent storage sets, each with its own capacity. When the engine has a free bank, it raises a schedule request for that bank and supplies the row that is currently open there. In the same cycle the block answers with the tag and row of the request to serve next, plus a flag saying whether that request continues an open row.

Inside one bank, requests are grouped by row. A request to the open row is preferred over older traffic. When nothing matches the open row, the row of the oldest request in the bank is taken, and this counts as a row miss (an activation). Once a row has been picked, the block locks onto it for that bank and streams the rest of its group, oldest first, before it looks at any other row. A mode register picks which set is served. Writes build up until their pending count reaches a high watermark. They are then drained until the count falls below a low watermark. The two thresholds give hysteresis, so the mode does not flip on every cycle.

Top module: `rowsched_top`

## Requirements
- R1: A grant only returns a request that was enqueued for the bank named by `schedBank`.
- R2: With no row locked for the bank in the active set, if a request of that bank has a row equal to `schedOpenRow`, the oldest such request is granted with `grantRowHit` = 1.
- R3: With no row locked and no request matching the open row, the row of the bank's oldest request is chosen. The oldest request of that row is granted with `grantRowHit` = 0.
- R4: After a grant, if requests of the same bank and row remain in that set, the row stays locked. Later grants for the bank then come from that row, oldest first, with `grantRowHit` = 1 whatever the open row is, until the group is empty.
- R5: The read set holds at most `RD_DEPTH` requests and the write set at most `WR_DEPTH`. `enqReady` is 1 exactly when the set selected by `enqWrite` (0 = read, 1 = write) is below its limit. An enqueue offered while `enqReady` = 0 is dropped and never granted.
- R6: On a cycle with `schedValid` = 1, read mode changes to write mode if pending writes are at least `WR_HI`, and write mode changes to read mode if pending writes are below `WR_LO`. The mode is not re-evaluated on other cycles. `grantWrite` shows the mode used for the current grant, and `writeMode` shows the registered mode (0 = read).
- R7: In write mode only the write set and its row locks are used, and in read mode only the read set and its row locks. The locks of one set are not changed by grants from the other set.
- R8: `grantValid` is 0 when `schedValid` is 0, or when the active set holds no request for the asked bank.
- R9: An accepted enqueue and a grant from the same set in one cycle leave that set's pending count unchanged. A request enqueued in a cycle is not a candidate for a grant in that same cycle.
- R10: After reset both sets are empty, the mode is read, no row is locked and `enqReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Enqueue offer |
| enqWrite | input | 1 | Direction of the offered request, 1 = write |
| enqBank | input | BANK_W | Bank of the offered request |
| enqRow | input | ROW_W | Row of the offered request |
| enqTag | input | TAG_W | Caller's tag for the request |
| enqReady | output | 1 | Selected set has room; offer is taken when valid and ready |
| schedValid | input | 1 | Schedule request for one bank |
| schedBank | input | BANK_W | Bank to schedule |
| schedOpenRow | input | ROW_W | Row currently open in that bank |
| grantValid | output | 1 | A request is granted this cycle (combinational) |
| grantWrite | output | 1 | Set the grant came from, 1 = write |
| grantRow | output | ROW_W | Row of the granted request |
| grantTag | output | TAG_W | Tag of the granted request |
| grantRowHit | output | 1 | 1 when the grant continues a lock or matches the open row |
| writeMode | output | 1 | Registered drain mode, 1 = write |

## Verification
The assertions assume that `schedBank` and `enqBank` are always below `NUM_BANKS`, and that the grant is consumed in the cycle it is shown, since the dequeue happens at the following edge with no handshake. They also assume `WR_LO` is below `WR_HI`. The stimulus draws banks only from the legal range and keeps the default watermarks in that order. It offers enqueues freely, including while `enqReady` is low, because dropping such an offer is itself part of the checked behaviour. Rows are drawn from a small set so that open-row matches, locked streams and row misses all happen often.

// File: rtl/rowsched_pkg.sv
package rowsched_pkg;

  // Strobes from the control unit into the two storage pools.
  typedef struct packed {
    logic rdPush;
    logic wrPush;
    logic rdPop;
    logic wrPop;
  } strobe_t;

endpackage

// File: rtl/rowsched_pool.sv
module rowsched_pool #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8,
  parameter int TAG_W  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [BANK_W-1:0] pushBank,
  input  logic [ROW_W-1:0]  pushRow,
  input  logic [TAG_W-1:0]  pushTag,
  input  logic              pop,
  input  logic [BANK_W-1:0] qBank,
  input  logic [ROW_W-1:0]  qOpenRow,
  input  logic              lockVld,
  input  logic [ROW_W-1:0]  lockRow,
  output logic              anyInBank,
  output logic              pickHit,
  output logic [ROW_W-1:0]  pickRow,
  output logic [TAG_W-1:0]  pickTag,
  output logic              lastInGroup,
  output logic [CNT_W-1:0]  occupancy
);

  logic [DEPTH-1:0] entVld;
  logic [BANK_W-1:0] entBank [DEPTH];
  logic [ROW_W-1:0]  entRow  [DEPTH];
  logic [TAG_W-1:0]  entTag  [DEPTH];
  logic [IDX_W-1:0]  entRank [DEPTH];   // 0 = oldest valid entry

  logic              openHit;
  logic [ROW_W-1:0]  oldRow;
  logic [IDX_W-1:0]  oldRank;
  logic [IDX_W-1:0]  pickIdx;
  logic [IDX_W-1:0]  pickRank;
  logic [CNT_W-1:0]  groupCnt;
  logic [IDX_W-1:0]  freeIdx;
  logic [IDX_W-1:0]  newRank;

  // Stage 1: bank presence, open-row match and oldest row of the bank.
  always_comb begin
    anyInBank = 1'b0;
    openHit   = 1'b0;
    oldRow    = '0;
    oldRank   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (entVld[i] && entBank[i] == qBank) begin
        if (entRow[i] == qOpenRow) openHit = 1'b1;
        if (!anyInBank || entRank[i] < oldRank) begin
          oldRow  = entRow[i];
          oldRank = entRank[i];
        end
        anyInBank = 1'b1;
      end
    end
    pickHit = lockVld || openHit;
    pickRow = lockVld ? lockRow : (openHit ? qOpenRow : oldRow);
  end

  // Stage 2: oldest entry of the chosen row group and group size.
  always_comb begin
    pickIdx  = '0;
    pickRank = '0;
    groupCnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (entVld[i] && entBank[i] == qBank && entRow[i] == pickRow) begin
        if (groupCnt == '0 || entRank[i] < pickRank) begin
          pickIdx  = IDX_W'(i);
          pickRank = entRank[i];
        end
        groupCnt = groupCnt + CNT_W'(1);
      end
    end
    lastInGroup = (groupCnt == CNT_W'(1));
    pickTag     = entTag[pickIdx];
  end

  always_comb begin
    freeIdx   = '0;
    occupancy = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!entVld[i]) freeIdx = IDX_W'(i);
      else occupancy = occupancy + CNT_W'(1);
    end
    newRank = IDX_W'(occupancy - CNT_W'(pop));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entVld <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pop && IDX_W'(i) == pickIdx) entVld[i] <= 1'b0;
        else if (pop && entVld[i] && entRank[i] > pickRank)
          entRank[i] <= entRank[i] - IDX_W'(1);
      end
      if (push) begin
        entVld[freeIdx]  <= 1'b1;
        entBank[freeIdx] <= pushBank;
        entRow[freeIdx]  <= pushRow;
        entTag[freeIdx]  <= pushTag;
        entRank[freeIdx] <= newRank;
      end
    end
  end

  // R4: a locked row always still has queued members.
  a_r4_lock_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    lockVld |-> groupCnt != '0);

  // R1: the picked entry belongs to the asked bank.
  a_r1_pick_bank: assert property (@(posedge clk) disable iff (!rstN)
    anyInBank |-> (entVld[pickIdx] && entBank[pickIdx] == qBank));

endmodule

// File: rtl/rowsched_ctrl.sv
module rowsched_ctrl
  import rowsched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 8,
  parameter int RD_DEPTH  = 8,
  parameter int WR_DEPTH  = 8,
  parameter int WR_HI     = 6,
  parameter int WR_LO     = 3,
  localparam int RD_CNT_W = $clog2(RD_DEPTH + 1),
  localparam int WR_CNT_W = $clog2(WR_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enqValid,
  input  logic                enqWrite,
  output logic                enqReady,
  input  logic                schedValid,
  input  logic [BANK_W-1:0]   schedBank,
  input  logic                rdAny,
  input  logic                rdLast,
  input  logic [ROW_W-1:0]    rdRow,
  input  logic [RD_CNT_W-1:0] rdOcc,
  input  logic                wrAny,
  input  logic                wrLast,
  input  logic [ROW_W-1:0]    wrRow,
  input  logic [WR_CNT_W-1:0] wrOcc,
  output strobe_t             strb,
  output logic                activeWrite,
  output logic                modeWrite,
  output logic                rdLockVld,
  output logic [ROW_W-1:0]    rdLockRow,
  output logic                wrLockVld,
  output logic [ROW_W-1:0]    wrLockRow
);

  localparam logic [RD_CNT_W-1:0] RD_LIM = RD_CNT_W'(RD_DEPTH);
  localparam logic [WR_CNT_W-1:0] WR_LIM = WR_CNT_W'(WR_DEPTH);
  localparam logic [WR_CNT_W-1:0] HI_MARK = WR_CNT_W'(WR_HI);
  localparam logic [WR_CNT_W-1:0] LO_MARK = WR_CNT_W'(WR_LO);

  logic [RD_CNT_W-1:0] rdCnt;
  logic [WR_CNT_W-1:0] wrCnt;
  logic [NUM_BANKS-1:0] rdLockV, wrLockV;
  logic [ROW_W-1:0] rdLockR [NUM_BANKS];
  logic [ROW_W-1:0] wrLockR [NUM_BANKS];

  always_comb begin
    activeWrite = modeWrite;
    if (!modeWrite && wrCnt >= HI_MARK) activeWrite = 1'b1;
    else if (modeWrite && wrCnt < LO_MARK) activeWrite = 1'b0;
  end

  assign enqReady    = enqWrite ? (wrCnt < WR_LIM) : (rdCnt < RD_LIM);
  assign strb.rdPush = enqValid && !enqWrite && (rdCnt < RD_LIM);
  assign strb.wrPush = enqValid && enqWrite && (wrCnt < WR_LIM);
  assign strb.rdPop  = schedValid && !activeWrite && rdAny;
  assign strb.wrPop  = schedValid && activeWrite && wrAny;

  assign rdLockVld = rdLockV[schedBank];
  assign rdLockRow = rdLockR[schedBank];
  assign wrLockVld = wrLockV[schedBank];
  assign wrLockRow = wrLockR[schedBank];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCnt     <= '0;
      wrCnt     <= '0;
      modeWrite <= 1'b0;
      rdLockV   <= '0;
      wrLockV   <= '0;
    end else begin
      rdCnt <= rdCnt + RD_CNT_W'(strb.rdPush) - RD_CNT_W'(strb.rdPop);
      wrCnt <= wrCnt + WR_CNT_W'(strb.wrPush) - WR_CNT_W'(strb.wrPop);
      if (schedValid) modeWrite <= activeWrite;
      if (strb.rdPop) begin
        rdLockV[schedBank] <= !rdLast;
        rdLockR[schedBank] <= rdRow;
      end
      if (strb.wrPop) begin
        wrLockV[schedBank] <= !wrLast;
        wrLockR[schedBank] <= wrRow;
      end
    end
  end

  // R5: the counters agree with the pools' own occupancy.
  a_r5_rd_count: assert property (@(posedge clk) disable iff (!rstN)
    rdCnt == rdOcc);
  a_r5_wr_count: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt == wrOcc && wrOcc <= WR_LIM);

  // R6: watermark hysteresis.
  a_r6_enter_write: assert property (@(posedge clk) disable iff (!rstN)
    (schedValid && !modeWrite && wrCnt >= HI_MARK) |=> modeWrite);
  a_r6_leave_write: assert property (@(posedge clk) disable iff (!rstN)
    (schedValid && modeWrite && wrCnt < LO_MARK) |=> !modeWrite);
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !schedValid |=> $stable(modeWrite));

  // R9: simultaneous push and pop keep the pool occupancy.
  a_r9_rd_balance: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdPush && strb.rdPop) |=> rdOcc == $past(rdOcc));

endmodule

// File: rtl/rowsched_top.sv
module rowsched_top
  import rowsched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int TAG_W     = 8,
  parameter int RD_DEPTH  = 8,
  parameter int WR_DEPTH  = 8,
  parameter int WR_HI     = 6,
  parameter int WR_LO     = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  input  logic              enqWrite,
  input  logic [BANK_W-1:0] enqBank,
  input  logic [ROW_W-1:0]  enqRow,
  input  logic [TAG_W-1:0]  enqTag,
  output logic              enqReady,
  input  logic              schedValid,
  input  logic [BANK_W-1:0] schedBank,
  input  logic [ROW_W-1:0]  schedOpenRow,
  output logic              grantValid,
  output logic              grantWrite,
  output logic [ROW_W-1:0]  grantRow,
  output logic [TAG_W-1:0]  grantTag,
  output logic              grantRowHit,
  output logic              writeMode
);

  localparam int RD_CNT_W = $clog2(RD_DEPTH + 1);
  localparam int WR_CNT_W = $clog2(WR_DEPTH + 1);

  strobe_t strb;
  logic activeWrite;
  logic rdAny, rdLast, rdHit, wrAny, wrLast, wrHit;
  logic [ROW_W-1:0] rdRow, wrRow, rdLockRow, wrLockRow;
  logic [TAG_W-1:0] rdTag, wrTag;
  logic rdLockVld, wrLockVld;
  logic [RD_CNT_W-1:0] rdOcc;
  logic [WR_CNT_W-1:0] wrOcc;

  rowsched_ctrl #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH), .WR_HI(WR_HI), .WR_LO(WR_LO)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqWrite(enqWrite),
    .enqReady(enqReady), .schedValid(schedValid), .schedBank(schedBank),
    .rdAny(rdAny), .rdLast(rdLast), .rdRow(rdRow), .rdOcc(rdOcc),
    .wrAny(wrAny), .wrLast(wrLast), .wrRow(wrRow), .wrOcc(wrOcc),
    .strb(strb), .activeWrite(activeWrite), .modeWrite(writeMode),
    .rdLockVld(rdLockVld), .rdLockRow(rdLockRow),
    .wrLockVld(wrLockVld), .wrLockRow(wrLockRow)
  );

  rowsched_pool #(
    .DEPTH(RD_DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .TAG_W(TAG_W)
  ) uRdPool (
    .clk(clk), .rstN(rstN), .push(strb.rdPush), .pushBank(enqBank),
    .pushRow(enqRow), .pushTag(enqTag), .pop(strb.rdPop), .qBank(schedBank),
    .qOpenRow(schedOpenRow), .lockVld(rdLockVld), .lockRow(rdLockRow),
    .anyInBank(rdAny), .pickHit(rdHit), .pickRow(rdRow), .pickTag(rdTag),
    .lastInGroup(rdLast), .occupancy(rdOcc)
  );

  rowsched_pool #(
    .DEPTH(WR_DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .TAG_W(TAG_W)
  ) uWrPool (
    .clk(clk), .rstN(rstN), .push(strb.wrPush), .pushBank(enqBank),
    .pushRow(enqRow), .pushTag(enqTag), .pop(strb.wrPop), .qBank(schedBank),
    .qOpenRow(schedOpenRow), .lockVld(wrLockVld), .lockRow(wrLockRow),
    .anyInBank(wrAny), .pickHit(wrHit), .pickRow(wrRow), .pickTag(wrTag),
    .lastInGroup(wrLast), .occupancy(wrOcc)
  );

  assign grantValid  = strb.rdPop || strb.wrPop;
  assign grantWrite  = activeWrite;
  assign grantRow    = activeWrite ? wrRow : rdRow;
  assign grantTag    = activeWrite ? wrTag : rdTag;
  assign grantRowHit = activeWrite ? wrHit : rdHit;

  // R8: no grant without a schedule request.
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !schedValid |-> !grantValid);

  // R7: a grant never comes from the inactive set.
  a_r7_set_select: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grantWrite ? wrAny : rdAny));

endmodule

// File: tb/rowsched_top_test.sv
`timescale 1ns/1ps
module rowsched_top_test;

  localparam int NB = 4;
  localparam int RDD = 8;
  localparam int WRD = 8;
  localparam int HI = 6;
  localparam int LO = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enqValid = 1'b0, enqWrite = 1'b0;
  logic [1:0] enqBank = '0;
  logic [7:0] enqRow = '0, enqTag = '0;
  logic enqReady;
  logic schedValid = 1'b0;
  logic [1:0] schedBank = '0;
  logic [7:0] schedOpenRow = '0;
  logic grantValid, grantWrite, grantRowHit, writeMode;
  logic [7:0] grantRow, grantTag;

  always #2 clk = ~clk;

  rowsched_top uut (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqWrite(enqWrite),
    .enqBank(enqBank), .enqRow(enqRow), .enqTag(enqTag), .enqReady(enqReady),
    .schedValid(schedValid), .schedBank(schedBank), .schedOpenRow(schedOpenRow),
    .grantValid(grantValid), .grantWrite(grantWrite), .grantRow(grantRow),
    .grantTag(grantTag), .grantRowHit(grantRowHit), .writeMode(writeMode)
  );

  int checks = 0;
  int errors = 0;

  // Reference model: per set (0 read, 1 write) and bank, arrival-ordered queues.
  int qRow[2][NB][$];
  int qTag[2][NB][$];
  bit lockV[2][NB];
  int lockR[2][NB];
  bit modeW = 0;
  int cnt[2] = '{0, 0};
  int tagCtr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare outputs against the model, then advance the model by one edge.
  task automatic stepModel();
    bit eff;
    bit expValid, expHit;
    int b, tr, idx, remain;
    bit expReady;
    eff = modeW;
    if (!modeW && cnt[1] >= HI) eff = 1;
    else if (modeW && cnt[1] < LO) eff = 0;
    expReady = enqWrite ? (cnt[1] < WRD) : (cnt[0] < RDD);
    chk(enqReady == expReady, "R5 enqReady", enqReady, expReady);
    chk(writeMode == modeW, "R6 writeMode", writeMode, modeW);
    expValid = 0; expHit = 0; tr = 0; idx = -1;
    b = schedBank;
    if (schedValid && qRow[eff][b].size() != 0) begin
      expValid = 1;
      if (lockV[eff][b]) begin
        tr = lockR[eff][b]; expHit = 1;            // R4 locked stream
      end else begin
        tr = -1;
        foreach (qRow[eff][b][k]) if (qRow[eff][b][k] == schedOpenRow) tr = schedOpenRow;
        if (tr >= 0) expHit = 1;                   // R2 open-row hit
        else begin tr = qRow[eff][b][0]; expHit = 0; end  // R3 miss
      end
      for (int k = qRow[eff][b].size() - 1; k >= 0; k--)
        if (qRow[eff][b][k] == tr) idx = k;
    end
    chk(grantValid == expValid, "R8 grantValid", grantValid, expValid);
    if (expValid && grantValid) begin
      chk(grantWrite == eff, "R7 grantWrite", grantWrite, eff);
      chk(grantRow == 8'(tr), "R1 grantRow", grantRow, tr);
      chk(grantTag == 8'(qTag[eff][b][idx]), "R4 grantTag order", grantTag, qTag[eff][b][idx]);
      chk(grantRowHit == expHit, expHit ? "R2 rowHit" : "R3 rowHit", grantRowHit, expHit);
    end
    if (schedValid) modeW = eff;
    if (expValid) begin
      qRow[eff][b].delete(idx);
      qTag[eff][b].delete(idx);
      cnt[eff]--;
      remain = 0;
      foreach (qRow[eff][b][k]) if (qRow[eff][b][k] == tr) remain++;
      lockV[eff][b] = (remain != 0);
      lockR[eff][b] = tr;
    end
    // R9: a same-cycle enqueue is added after the grant decision.
    if (enqValid && expReady) begin
      qRow[enqWrite][enqBank].push_back(enqRow);
      qTag[enqWrite][enqBank].push_back(enqTag);
      cnt[enqWrite]++;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int enqP, wrP, schP;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R10: state right after reset, with a schedule request on an empty block.
    schedValid = 1'b1;
    #1;
    chk(enqReady == 1'b1, "R10 enqReady", enqReady, 1);
    chk(writeMode == 1'b0, "R10 writeMode", writeMode, 0);
    chk(grantValid == 1'b0, "R10 grantValid", grantValid, 0);
    for (int ph = 0; ph < 9; ph++) begin
      case (ph % 3)
        0: begin enqP = 90; wrP = 50; schP = 20; end
        1: begin enqP = 80; wrP = 90; schP = 50; end
        default: begin enqP = 10; wrP = 40; schP = 95; end
      endcase
      for (int c = 0; c < 700; c++) begin
        @(negedge clk);
        enqValid     = ($urandom % 100) < enqP;
        enqWrite     = ($urandom % 100) < wrP;
        enqBank      = 2'($urandom % NB);
        enqRow       = 8'($urandom % 4);
        enqTag       = 8'(tagCtr);
        tagCtr       = (tagCtr + 1) % 256;
        schedValid   = ($urandom % 100) < schP;
        schedBank    = 2'($urandom % NB);
        schedOpenRow = 8'($urandom % 5);
        #1;
        stepModel();
      end
    end
    @(negedge clk);
    enqValid = 1'b0;
    schedValid = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule